// File: doc/BRIEF.md
# 3x3 Sliding Window Generator

This block sits on a raster pixel stream and builds a square neighbourhood of three rows by three columns around the stream position, ready for a downstream spatial operator such as an edge detector, median filter or threshold stage. Pixels arrive one per accepted cycle, qualified by a valid strobe. A frame-start flag marks the first pixel of a frame and a line-start flag marks the first pixel of a row.

Row history is held in three delay lines, each exactly one row long and chained in series. Every accepted pixel is written into the first line while each line gives up its oldest pixel, which is the pixel at the same column one, two or three rows earlier. Each of these three pixels moves into its own three-stage shift register. The nine register stages form the window, which therefore spans the three rows stored before the current one and the current column with the two columns to its left. A window-valid flag marks the windows that lie wholly inside the current frame. Kernel arithmetic and border padding are left to the consumer.

Top module: `sliding_window3x3`

## Requirements
- R1: While reset is asserted and after it is released, `win_valid_o` is 0, and the block counts from row 0, column 0 until three full rows have been accepted.
- R2: During the first three rows of a frame (rows 0, 1 and 2), `win_valid_o` stays 0.
- R3: From row 3 onward, the cycle after an accepted pixel at column c raises `win_valid_o` exactly when c >= 2. Columns 0 and 1 never produce a valid window.
- R4: For the pixel at row r, column c, window position p (1 to 9) sits at `win_o[(p-1)*PIX_W +: PIX_W]`. Positions run in raster order over rows r-3, r-2, r-1 (top to bottom) and columns c-2, c-1, c (left to right). Position 1 is the pixel at row r-3, column c-2 and position 9 is the pixel at row r-1, column c.
- R5: Over consecutive accepted pixels of a row, the window moves right by one column per pixel.
- R6: A cycle without an accepted pixel leaves `win_o` unchanged and drives `win_valid_o` to 0 in the following cycle.
- R7: A pixel accepted with `frame_start_i` = 1 is counted as row 0, column 0, so the three-row fill starts again at any point in the stream.
- R8: A pixel accepted with `line_start_i` = 1 is counted as column 0. If the previous row ended early (the column count was not 0), the row count also advances.
- R9: Without a line-start flag, the column count wraps to 0 after column LINE_W-1 and the row count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | A pixel is accepted in this cycle |
| pix_i | input | PIX_W | Pixel value |
| frame_start_i | input | 1 | Accepted pixel is the first of a frame |
| line_start_i | input | 1 | Accepted pixel is the first of a row |
| win_o | output | 9*PIX_W | Window pixels; position p at bits (p-1)*PIX_W upward |
| win_valid_o | output | 1 | Window is complete and inside one frame |

## Verification
Whole frames are streamed with horizontal ramps, vertical ramps and a pattern with a row-column product term. Each of these separates a window whose rows or columns are swapped or offset from the correct one, because every position in each window carries a different value. The patterns are sent back to back, with idle gaps inserted every few pixels, and once with a line-start flag on every row. These runs tell apart sliding that depends on cycles from sliding that depends on accepted pixels, and counting rows by wrap from counting them by flag. Directed runs restart a frame in the middle of a row, shorten a row that is then closed by a line-start flag, and reset the block in the middle of a frame. Each of these probes when the valid flag first reappears.

// File: rtl/win3_pkg.sv
package win3_pkg;

    // Row fill progress of the current frame; saturates at FILL_DONE.
    typedef enum logic [1:0] {
        FILL_R0   = 2'd0,
        FILL_R1   = 2'd1,
        FILL_R2   = 2'd2,
        FILL_DONE = 2'd3
    } fill_t;

    function automatic fill_t fill_next(input fill_t f);
        case (f)
            FILL_R0: return FILL_R1;
            FILL_R1: return FILL_R2;
            default: return FILL_DONE;
        endcase
    endfunction

endpackage

// File: rtl/win3_line_delay.sv
// One row of pixel history: read the old value and overwrite it at the same address.
module win3_line_delay #(
    parameter int DEPTH = 480,
    parameter int W     = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  din_i,
    output logic [W-1:0]  dout_o
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= din_i;
        end
    end

    assign dout_o = mem_q[addr_i];

endmodule

// File: rtl/win3_raster_tracker.sv
// Tracks row fill and column of the incoming stream.
module win3_raster_tracker
    import win3_pkg::*;
#(
    parameter int LINE_W = 480,
    parameter int COL_W  = $clog2(LINE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid_i,
    input  logic             sof_i,
    input  logic             sol_i,
    output logic [COL_W-1:0] col_o,
    output logic             win_ok_o
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_W - 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
        fill_t            fill;
    } trk_t;

    trk_t  st_d, st_q;
    fill_t fill_eff;
    logic [COL_W-1:0] col_eff;

    always_comb begin
        st_d = st_q;
        // Column and row of the pixel presented now (R7, R8)
        if (sof_i) begin
            col_eff  = '0;
            fill_eff = FILL_R0;
        end else if (sol_i) begin
            col_eff  = '0;
            fill_eff = (st_q.col != '0) ? fill_next(st_q.fill) : st_q.fill;
        end else begin
            col_eff  = st_q.col;
            fill_eff = st_q.fill;
        end
        if (pix_valid_i) begin
            if (col_eff == LAST_COL) begin      // R9 wrap
                st_d.col  = '0;
                st_d.fill = fill_next(fill_eff);
            end else begin
                st_d.col  = col_eff + 1'b1;
                st_d.fill = fill_eff;
            end
        end
        col_o    = col_eff;
        win_ok_o = pix_valid_i && (fill_eff == FILL_DONE) && (col_eff >= COL_W'(2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{col: '0, fill: FILL_R0};
        end else begin
            st_q <= st_d;
        end
    end

    a_r9_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.col <= LAST_COL);

    a_r7_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && sof_i) |=> (st_q.fill == FILL_R0 && st_q.col == COL_W'(1)));

    a_r2_fill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fill == FILL_DONE && !(pix_valid_i && sof_i)) |=> st_q.fill == FILL_DONE);

endmodule

// File: rtl/sliding_window3x3.sv
module sliding_window3x3 #(
    parameter int LINE_W = 480,
    parameter int PIX_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               pix_valid_i,
    input  logic [PIX_W-1:0]   pix_i,
    input  logic               frame_start_i,
    input  logic               line_start_i,
    output logic [9*PIX_W-1:0] win_o,
    output logic               win_valid_o
);

    localparam int COL_W = $clog2(LINE_W);
    localparam int NROW  = 3;
    localparam int NCOL  = 3;

    typedef struct packed {
        logic [NROW-1:0][NCOL-1:0][PIX_W-1:0] sr;   // [row tap][stage], stage 0 newest
        logic                                 vld;
    } win_st_t;

    win_st_t st_d, st_q;

    logic [COL_W-1:0] col;
    logic             win_ok;
    logic [PIX_W-1:0] tap   [NROW];
    logic [PIX_W-1:0] chain [NROW];

    win3_raster_tracker #(.LINE_W(LINE_W), .COL_W(COL_W)) trk_i (
        .clk         (clk_i),
        .rst_n       (rst_n_i),
        .pix_valid_i (pix_valid_i),
        .sof_i       (frame_start_i),
        .sol_i       (line_start_i),
        .col_o       (col),
        .win_ok_o    (win_ok)
    );

    // Three row delays in series; tap k holds the pixel k+1 rows back.
    for (genvar k = 0; k < NROW; k++) begin : g_line
        if (k == 0) begin : g_head
            assign chain[k] = pix_i;
        end else begin : g_link
            assign chain[k] = tap[k-1];
        end
        win3_line_delay #(.DEPTH(LINE_W), .W(PIX_W), .AW(COL_W)) dly_i (
            .clk    (clk_i),
            .we_i   (pix_valid_i),
            .addr_i (col),
            .din_i  (chain[k]),
            .dout_o (tap[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = win_ok;
        if (pix_valid_i) begin
            for (int k = 0; k < NROW; k++) begin
                for (int s = NCOL - 1; s > 0; s--) begin
                    st_d.sr[k][s] = st_q.sr[k][s-1];
                end
                st_d.sr[k][0] = tap[k];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Raster order: top row is oldest tap, left column is oldest stage (R4).
    for (genvar rr = 0; rr < NROW; rr++) begin : g_orow
        for (genvar cc = 0; cc < NCOL; cc++) begin : g_ocol
            assign win_o[(rr*NCOL+cc)*PIX_W +: PIX_W] = st_q.sr[NROW-1-rr][NCOL-1-cc];
        end
    end
    assign win_valid_o = st_q.vld;

    a_r6_valid_needs_pixel: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        win_valid_o |-> $past(pix_valid_i));

    a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !pix_valid_i |=> $stable(win_o));

    a_r5_slide_left: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (win_valid_o && $past(win_valid_o)) |->
            win_o[0 +: PIX_W] == $past(win_o[PIX_W +: PIX_W]));

endmodule

// File: tb/sliding_window3x3_tb_top.sv
module sliding_window3x3_tb_top;

    localparam int TW  = 8;
    localparam int PW  = 8;
    localparam int NSC = 4;
    // Scenario: [15:8] rows, [7:5] idle gap period (0 none), [4] line-start each row, [3:0] pattern
    localparam logic [15:0] SCEN [NSC] = '{16'h0501, 16'h0465, 16'h0656, 16'h0513};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0;
    logic [PW-1:0] pix = '0;
    logic sof = 1'b0;
    logic sol = 1'b0;
    logic [9*PW-1:0] win;
    logic win_valid;

    int tests = 0;
    int fails = 0;
    int mrow = 0;
    int mcol = 0;
    logic [PW-1:0] img [16][TW];

    always #2.5 clk = ~clk;

    sliding_window3x3 #(.LINE_W(TW), .PIX_W(PW)) dut_i (
        .clk_i         (clk),
        .rst_n_i       (rst_n),
        .pix_valid_i   (pix_valid),
        .pix_i         (pix),
        .frame_start_i (sof),
        .line_start_i  (sol),
        .win_o         (win),
        .win_valid_o   (win_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] pv(input int r, input int c, input int m);
        return PW'((r*37 + c*(2*m+1) + m*13 + r*c*m) & 255);
    endfunction

    // Send one accepted pixel and check the result one cycle later.
    task automatic push(input logic [PW-1:0] p, input bit f, input bit l, input bit chk_win, input string tag);
        int r, c;
        bit exp_v;
        logic [9*PW-1:0] exp_w;
        if (f) begin r = 0; c = 0; end
        else if (l) begin r = (mcol != 0) ? mrow + 1 : mrow; c = 0; end
        else begin r = mrow; c = mcol; end
        if (r < 16) img[r][c] = p;
        pix_valid = 1'b1; pix = p; sof = f; sol = l;
        @(negedge clk);
        exp_v = (r >= 3) && (c >= 2);
        check(win_valid === exp_v, $sformatf("%s valid r%0d c%0d", (r < 3) ? {tag, " R2"} : {tag, " R3"}, r, c),
              72'(win_valid), 72'(exp_v));
        if (exp_v && chk_win && r < 16) begin
            for (int q = 0; q < 9; q++) exp_w[q*PW +: PW] = img[r-3+q/3][c-2+q%3];
            check(win === exp_w, $sformatf("%s window R4 R5 r%0d c%0d", tag, r, c), win, exp_w);
        end
        mrow = r; mcol = c + 1;
        if (mcol == TW) begin mcol = 0; mrow = r + 1; end
    endtask

    task automatic idle(input int n, input string tag);
        logic [9*PW-1:0] prev;
        for (int i = 0; i < n; i++) begin
            prev = win;
            pix_valid = 1'b0; sof = 1'b0; sol = 1'b0;
            @(negedge clk);
            check(win_valid === 1'b0, {tag, " R6 idle valid"}, 72'(win_valid), 72'd0);
            check(win === prev, {tag, " R6 idle hold"}, win, prev);
        end
    endtask

    task automatic do_reset();
        pix_valid = 1'b0; sof = 1'b0; sol = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(win_valid === 1'b0, "R1 valid in reset", 72'(win_valid), 72'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(win_valid === 1'b0, "R1 valid after reset", 72'(win_valid), 72'd0);
        mrow = 0; mcol = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Table of frame scenarios (R2 R3 R4 R5 R6 R9)
        for (int s = 0; s < NSC; s++) begin
            int rows = int'(SCEN[s][15:8]);
            int gap  = int'(SCEN[s][7:5]);
            bit each = SCEN[s][4];
            int m    = int'(SCEN[s][3:0]);
            for (int r = 0; r < rows; r++) begin
                for (int c = 0; c < TW; c++) begin
                    push(pv(r, c, m), (r == 0 && c == 0), (each && c == 0), 1'b1, $sformatf("scen%0d", s));
                    if (gap != 0 && (c % gap) == gap - 1) idle(1, $sformatf("scen%0d", s));
                end
            end
            idle(2, $sformatf("scen%0d", s));
        end

        // R7: frame start in the middle of a row restarts the fill
        for (int c = 0; c < 3; c++) push(pv(9, c, 2), 1'b0, 1'b0, 1'b1, "R7 partial");
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < TW; c++) begin
                push(pv(r, c, 7), (r == 0 && c == 0), 1'b0, 1'b1, "R7 restart");
            end
        end
        idle(1, "R7");

        // R8: short row closed by a line-start flag advances the row count
        push(pv(0, 0, 4), 1'b1, 1'b0, 1'b0, "R8 short");
        for (int c = 1; c < TW; c++) push(pv(0, c, 4), 1'b0, 1'b0, 1'b0, "R8 short");
        for (int c = 0; c < 3; c++) push(pv(1, c, 4), 1'b0, 1'b0, 1'b0, "R8 short");
        for (int r = 2; r < 4; r++) begin
            for (int c = 0; c < TW; c++) begin
                push(pv(r, c, 4), 1'b0, (c == 0), 1'b0, "R8 short");
            end
        end

        // R1: reset in mid-frame restarts counting from row 0
        for (int c = 0; c < 3; c++) push(pv(4, c, 4), 1'b0, 1'b0, 1'b0, "R1 pre");
        do_reset();
        for (int c = 0; c < TW; c++) push(pv(0, c, 1), 1'b0, 1'b0, 1'b0, "R1 after reset");
        idle(1, "R1");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule